// File: doc/BRIEF.md
# Textured Line Draw Engine

This block draws a straight line into a one-bit-per-pixel bitplane kept in word-addressed memory with 16 pixels per word. After a start strobe it walks the line one pixel at a time using an integer error term. For each pixel it reads the word that holds the pixel, merges the pixel into that word, and writes the word back to the same address. The merge uses a single-bit pixel mask, a rotating 16-bit texture pattern and the old memory contents. The engine signals busy while it works and pulses done when it has finished.

The caller supplies the following:
- the major and minor lengths of the line;
- three octant bits;
- the word address and pixel position of the first pixel;
- the row stride in words;
- the texture pattern;
- two mode flags. One flag selects an XOR draw, which makes a line erasable. The other selects one-dot drawing, which plots at most one pixel per row so that the result can serve as the outline for a later area fill.

The memory port is that of a synchronous RAM. Read data is valid in the cycle after a read request. A write takes effect at the clock edge that ends the write cycle.

Top module: `line_draw_engine`

## Requirements
- R1: A line with major length M touches exactly M+1 pixels, the first and the last pixel included. This gives M+1 read/write pairs. M=0 draws one pixel.
- R2: The error term starts at 4*minor-2*major. After each pixel except the last:
  - If the term is negative, 4*minor is added and the line steps along the major axis only.
  - Otherwise 4*(minor-major) is added and the line steps along both axes.
- R3: The octant bits are x_neg (x decreases), y_neg (y decreases) and y_major (y is the major axis).
  - Pixel position 0 is the most significant bit of a word and position 15 is the least significant.
  - An x step moves the position by one. Moving past 15 carries to address+1, and moving below 0 borrows from address-1.
  - A y step adds row_stride to the address, or subtracts it when y_neg is set.
- R4: In normal mode (xor_mode=0) a plotted pixel bit takes the value of the current pattern bit. Every other bit of the word keeps its old value.
- R5: In XOR mode (xor_mode=1) a plotted pixel bit is inverted when the pattern bit is 1 and left unchanged when it is 0. Drawing the same line twice restores the memory.
- R6: Pixel k uses pattern bit 15-(k mod 16). The pattern therefore starts at its most significant bit and rotates by one for every pixel. The value 16'hFFFF draws a solid line.
- R7: With one_dot=1 the engine plots the first pixel and each pixel that follows a y step. Other pixels are still read and written, but their words are written back unchanged.
- R8: Each pixel takes 3 cycles: a read cycle, a merge cycle, and a write cycle to the address that was read. The read and write strobes are never high together.
- R9: done is high for exactly one cycle, in the cycle after the last write. At that time busy is low. done rises 3*(M+1) clock edges after the edge that sampled start.
- R10: A start strobe that arrives while busy is high has no effect on the line being drawn or on its timing.
- R11: After reset, busy, done, mem_rd and mem_wr are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a line; sampled only while idle |
| major_len | input | LEN_W | Larger of abs(dx) and abs(dy) |
| minor_len | input | LEN_W | Smaller of abs(dx) and abs(dy) |
| x_neg | input | 1 | x decreases along the line |
| y_neg | input | 1 | y decreases along the line |
| y_major | input | 1 | y is the major axis |
| start_addr | input | ADDR_W | Word address of the first pixel |
| start_bit | input | 4 | Pixel position of the first pixel, 0 = MSB |
| row_stride | input | ADDR_W | Words per bitplane row |
| pattern | input | 16 | Texture pattern |
| xor_mode | input | 1 | 1 = invert, 0 = write pattern bit |
| one_dot | input | 1 | Plot at most one pixel per row |
| mem_addr | output | ADDR_W | Memory word address |
| mem_rd | output | 1 | Read request; data valid in the next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data from the memory |
| busy | output | 1 | Line in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Each pixel costs three cycles, so the done pulse is due exactly 3*(M+1) edges after the edge that samples start. The bench counts edges from that point and compares the count with this figure, sampling on the falling edge. It then checks on the next falling edge that done has dropped. A bench RAM with one cycle of read latency serves the engine. After done, the bench compares the whole RAM word by word with a model image built by an independent coordinate-based line walk. It also checks the number of write strobes against M+1. Inputs change only on falling edges, so no decision depends on the order of processes at the rising edge.

// File: rtl/line_draw_pkg.sv
package line_draw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_MERGE = 2'd2,
    ST_WRITE = 2'd3
  } ld_state_e;

  typedef struct packed {
    logic x_neg;
    logic y_neg;
    logic y_major;
  } octant_t;
endpackage

// File: rtl/line_stepper.sv
module line_stepper
  import line_draw_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              adv,
  input  logic [LEN_W-1:0]  major_len,
  input  logic [LEN_W-1:0]  minor_len,
  input  octant_t           octant,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [3:0]        start_bit,
  input  logic [ADDR_W-1:0] row_stride,
  input  logic [15:0]       pattern,
  input  logic              one_dot,
  output logic [ADDR_W-1:0] addr,
  output logic [15:0]       pix_mask,
  output logic              pat_bit,
  output logic              plot_en,
  output logic              last
);
  localparam int ERR_W = LEN_W + 4;

  logic signed [ERR_W-1:0] err, inc_straight, inc_diag;
  logic signed [ERR_W-1:0] maj_s, min_s;
  logic [LEN_W-1:0]  cnt;
  logic [3:0]        pix;
  logic [15:0]       pat;
  logic [ADDR_W-1:0] stride;
  octant_t           oct;
  logic              od, row_moved;

  logic              diag, x_mv, y_mv;
  logic [3:0]        pix_nx;
  logic [ADDR_W-1:0] addr_x, addr_nx;

  assign maj_s = ERR_W'(major_len);
  assign min_s = ERR_W'(minor_len);

  // step decision and next position
  always_comb begin
    diag   = !err[ERR_W-1];
    x_mv   = oct.y_major ? diag : 1'b1;
    y_mv   = oct.y_major ? 1'b1 : diag;
    pix_nx = pix;
    addr_x = addr;
    if (x_mv) begin
      if (!oct.x_neg) begin
        pix_nx = pix + 4'd1;
        if (pix == 4'd15) addr_x = addr + ADDR_W'(1);
      end else begin
        pix_nx = pix - 4'd1;
        if (pix == 4'd0) addr_x = addr - ADDR_W'(1);
      end
    end
    addr_nx = addr_x;
    if (y_mv) addr_nx = oct.y_neg ? addr_x - stride : addr_x + stride;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err          <= '0;
      inc_straight <= '0;
      inc_diag     <= '0;
      cnt          <= '0;
      pix          <= '0;
      pat          <= '0;
      addr         <= '0;
      stride       <= '0;
      oct          <= '0;
      od           <= 1'b0;
      row_moved    <= 1'b1;
    end else if (load) begin
      err          <= (min_s <<< 2) - (maj_s <<< 1);
      inc_straight <= min_s <<< 2;
      inc_diag     <= (min_s - maj_s) <<< 2;
      cnt          <= major_len;
      pix          <= start_bit;
      pat          <= pattern;
      addr         <= start_addr;
      stride       <= row_stride;
      oct          <= octant;
      od           <= one_dot;
      row_moved    <= 1'b1;
    end else if (adv) begin
      err       <= err + (diag ? inc_diag : inc_straight);
      cnt       <= cnt - LEN_W'(1);
      pix       <= pix_nx;
      addr      <= addr_nx;
      pat       <= {pat[14:0], pat[15]};
      row_moved <= y_mv;
    end
  end

  assign pix_mask = 16'h8000 >> pix;
  assign pat_bit  = pat[15];
  assign plot_en  = !od || row_moved;
  assign last     = (cnt == '0);

  // R6: rotation never gains or loses pattern bits
  assert_pat_rot_R6: assert property (@(posedge clk) disable iff (rst)
    adv |=> $countones(pat) == $countones($past(pat)));

  // R2: a straight step never makes the error term smaller
  assert_err_straight_R2: assert property (@(posedge clk) disable iff (rst)
    (adv && !diag) |=> err >= $past(err));
endmodule

// File: rtl/line_merge.sv
module line_merge (
  input  logic [15:0] old_word,
  input  logic [15:0] mask,
  input  logic        pat_bit,
  input  logic        xor_mode,
  input  logic        plot_en,
  output logic [15:0] new_word
);
  for (genvar i = 0; i < 16; i++) begin : g_bit
    logic hit;
    assign hit         = mask[i] & plot_en;
    assign new_word[i] = hit ? (xor_mode ? (old_word[i] ^ pat_bit) : pat_bit)
                             : old_word[i];
  end
endmodule

// File: rtl/line_draw_engine.sv
module line_draw_engine
  import line_draw_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [LEN_W-1:0]  major_len,
  input  logic [LEN_W-1:0]  minor_len,
  input  logic              x_neg,
  input  logic              y_neg,
  input  logic              y_major,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [3:0]        start_bit,
  input  logic [ADDR_W-1:0] row_stride,
  input  logic [15:0]       pattern,
  input  logic              xor_mode,
  input  logic              one_dot,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [15:0]       mem_wdata,
  input  logic [15:0]       mem_rdata,
  output logic              busy,
  output logic              done
);
  ld_state_e   state;
  logic        xm;
  logic        load, adv;
  logic [15:0] mask, merged;
  logic        pat_bit, plot_en, last;
  octant_t     oct_in;

  assign oct_in = '{x_neg: x_neg, y_neg: y_neg, y_major: y_major};
  assign load   = (state == ST_IDLE) && start;
  assign adv    = (state == ST_WRITE) && !last;

  line_stepper #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_step (
    .clk(clk), .rst(rst), .load(load), .adv(adv),
    .major_len(major_len), .minor_len(minor_len), .octant(oct_in),
    .start_addr(start_addr), .start_bit(start_bit), .row_stride(row_stride),
    .pattern(pattern), .one_dot(one_dot),
    .addr(mem_addr), .pix_mask(mask), .pat_bit(pat_bit),
    .plot_en(plot_en), .last(last)
  );

  line_merge u_merge (
    .old_word(mem_rdata), .mask(mask), .pat_bit(pat_bit),
    .xor_mode(xm), .plot_en(plot_en), .new_word(merged)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      busy      <= 1'b0;
      done      <= 1'b0;
      mem_rd    <= 1'b0;
      mem_wr    <= 1'b0;
      mem_wdata <= '0;
      xm        <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          state  <= ST_READ;
          busy   <= 1'b1;
          mem_rd <= 1'b1;
          xm     <= xor_mode;
        end
        ST_READ: begin
          mem_rd <= 1'b0;
          state  <= ST_MERGE;
        end
        ST_MERGE: begin
          mem_wdata <= merged;
          mem_wr    <= 1'b1;
          state     <= ST_WRITE;
        end
        default: begin
          mem_wr <= 1'b0;
          if (last) begin
            state <= ST_IDLE;
            busy  <= 1'b0;
            done  <= 1'b1;
          end else begin
            state  <= ST_READ;
            mem_rd <= 1'b1;
          end
        end
      endcase
    end
  end

  // R8: strobes exclusive
  assert_rw_excl_R8: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  // R8: write goes to the address read two cycles earlier
  assert_rmw_addr_R8: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> ($past(mem_rd, 2) && mem_addr == $past(mem_addr, 2)));

  // R4: bits outside the pixel mask keep the value read
  assert_keep_bits_R4: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> ((mem_wdata ^ $past(mem_rdata)) & ~$past(mask)) == 16'h0);

  // R9: done follows the final write, busy already low, one cycle only
  assert_done_after_wr_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(mem_wr) && !busy));
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10: a start while busy does not restart the read sequence
  assert_start_ignored_R10: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !mem_wr) |=> !mem_rd || $past(state == ST_WRITE) || $past(state == ST_IDLE));
endmodule

// File: tb/line_draw_engine_bench.sv
`timescale 1ns/1ps
module line_draw_engine_bench;
  localparam int ADDR_W = 16;
  localparam int LEN_W  = 10;
  localparam int MEM_N  = 4096;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [LEN_W-1:0] major_len = '0, minor_len = '0;
  logic x_neg = 1'b0, y_neg = 1'b0, y_major = 1'b0;
  logic [ADDR_W-1:0] start_addr = '0, row_stride = '0;
  logic [3:0] start_bit = '0;
  logic [15:0] pattern = '0;
  logic xor_mode = 1'b0, one_dot = 1'b0;
  logic [ADDR_W-1:0] mem_addr;
  logic mem_rd, mem_wr, busy, done;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;

  logic [15:0] dmem [MEM_N];
  logic [15:0] emem [MEM_N];
  logic [15:0] snap [MEM_N];
  int checks = 0, errors = 0, wr_cnt = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  line_draw_engine #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_line_draw_engine (
    .clk(clk), .rst(rst), .start(start), .major_len(major_len), .minor_len(minor_len),
    .x_neg(x_neg), .y_neg(y_neg), .y_major(y_major), .start_addr(start_addr),
    .start_bit(start_bit), .row_stride(row_stride), .pattern(pattern),
    .xor_mode(xor_mode), .one_dot(one_dot), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .busy(busy), .done(done)
  );

  function automatic logic [15:0] seed_word(int i);
    return 16'((i * 40503) ^ (i >>> 3) ^ 16'h5A3C);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < MEM_N; i++) dmem[i] <= seed_word(i);
    end else begin
      if (mem_wr) dmem[mem_addr[11:0]] <= mem_wdata;
      if (mem_rd) mem_rdata <= dmem[mem_addr[11:0]];
      if (mem_wr) wr_cnt <= wr_cnt + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int fdiv16(int x);
    return (x >= 0) ? x / 16 : -((-x + 15) / 16);
  endfunction

  // independent coordinate-based model of the line walk
  task automatic ref_draw(input int maj, input int mi, input bit xn, input bit yn,
                          input bit ym, input int base, input int b0, input int stride,
                          input logic [15:0] pat, input bit xr, input bit od);
    int e, x, y, w, bitpos;
    bit prev_y, dg;
    logic [15:0] p;
    e = 4 * mi - 2 * maj; x = b0; y = 0; prev_y = 1; p = pat;
    for (int k = 0; k <= maj; k++) begin
      w = (base + y * stride + fdiv16(x)) & (MEM_N - 1);
      bitpos = x - 16 * fdiv16(x);
      if (!od || prev_y) begin
        if (xr) emem[w][15 - bitpos] = emem[w][15 - bitpos] ^ p[15];
        else    emem[w][15 - bitpos] = p[15];
      end
      p = {p[14:0], p[15]};
      dg = (e >= 0);
      e = e + (dg ? 4 * (mi - maj) : 4 * mi);
      if (ym ? dg : 1'b1) x = x + (xn ? -1 : 1);
      if (ym ? 1'b1 : dg) y = y + (yn ? -1 : 1);
      prev_y = ym ? 1'b1 : dg;
    end
  endtask

  task automatic check_mem(input string req, input bit vs_snap);
    int bad, first, a, e;
    bad = 0; first = -1; a = 0; e = 0;
    for (int i = 0; i < MEM_N; i++) begin
      if (dmem[i] !== (vs_snap ? snap[i] : emem[i])) begin
        if (first < 0) begin
          first = i; a = int'(dmem[i]); e = int'(vs_snap ? snap[i] : emem[i]);
        end
        bad++;
      end
    end
    check(bad == 0, req, $sformatf("memory word %0d", first), a, e);
  endtask

  task automatic run_line(input int maj, input int mi, input bit xn, input bit yn,
                          input bit ym, input int base, input int b0, input int stride,
                          input logic [15:0] pat, input bit xr, input bit od,
                          input string req, input bit extra_start);
    int n;
    bit seen;
    @(negedge clk);
    major_len = LEN_W'(maj); minor_len = LEN_W'(mi);
    x_neg = xn; y_neg = yn; y_major = ym;
    start_addr = ADDR_W'(base); start_bit = 4'(b0); row_stride = ADDR_W'(stride);
    pattern = pat; xor_mode = xr; one_dot = od;
    wr_cnt = 0;
    start = 1'b1;
    @(posedge clk);
    n = 0; seen = 0;
    @(negedge clk);
    start = 1'b0;
    for (int t = 0; t < 20000 && !seen; t++) begin
      if (done) seen = 1;
      else begin
        if (extra_start && n == 4) begin
          start = 1'b1; major_len = 10'd3; x_neg = ~xn; pattern = 16'h0;
          start_addr = ADDR_W'(base + 100);
        end else start = 1'b0;
        @(posedge clk); n++;
        @(negedge clk);
      end
    end
    start = 1'b0;
    check(seen, "R9", "done seen before timeout", int'(seen), 1);
    check(n == 3 * (maj + 1), extra_start ? "R10" : "R9", "edges from start to done", n, 3 * (maj + 1));
    check(wr_cnt == maj + 1, "R1", "write strobes", wr_cnt, maj + 1);
    check(!busy, "R9", "busy low with done", int'(busy), 0);
    @(negedge clk);
    check(!done, "R9", "done one cycle", int'(done), 0);
    ref_draw(maj, mi, xn, yn, ym, base, b0, stride, pat, xr, od);
    check_mem(req, 1'b0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < MEM_N; i++) emem[i] = seed_word(i);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !done && !mem_rd && !mem_wr, "R11", "idle outputs after reset",
          int'({busy, done, mem_rd, mem_wr}), 0);
    check_mem("R11", 1'b0);

    // R3 R4: horizontal right, word carry, solid
    run_line(20, 0, 0, 0, 0, 2048, 10, 16, 16'hFFFF, 0, 0, "R3", 0);
    // R3: leftward with borrow, shallow slope
    run_line(9, 3, 1, 0, 0, 2300, 2, 16, 16'hFFFF, 0, 0, "R3", 0);
    // R4: pattern zero clears pixels
    run_line(12, 5, 0, 1, 0, 2600, 7, 16, 16'h0000, 0, 0, "R4", 0);
    // R6: textured line longer than one pattern period
    run_line(30, 11, 0, 0, 0, 1500, 0, 16, 16'hA5C3, 0, 0, "R6", 0);
    // R2: steep line, y major, y decreasing
    run_line(25, 9, 1, 1, 1, 2900, 5, 16, 16'hFFFF, 0, 0, "R2", 0);
    // R1: single pixel
    run_line(0, 0, 0, 0, 0, 1000, 15, 16, 16'hFFFF, 0, 0, "R1", 0);
    // R7: one-dot shallow line
    run_line(24, 7, 0, 0, 0, 1200, 3, 16, 16'hFFFF, 0, 1, "R7", 0);
    // R7: one-dot steep line plots every pixel
    run_line(15, 6, 1, 0, 1, 1700, 8, 16, 16'hF0F0, 0, 1, "R7", 0);
    // R5: xor twice restores memory
    for (int i = 0; i < MEM_N; i++) snap[i] = dmem[i];
    run_line(18, 13, 0, 1, 0, 3000, 12, 16, 16'hFFFF, 1, 0, "R5", 0);
    run_line(18, 13, 0, 1, 0, 3000, 12, 16, 16'hFFFF, 1, 0, "R5", 0);
    check_mem("R5", 1'b1);
    // R10: start strobe during a line is ignored
    run_line(14, 4, 0, 0, 0, 2200, 6, 16, 16'hFFFF, 0, 0, "R10", 1);

    // random lines
    for (int r = 0; r < 24; r++) begin
      int maj, mi;
      maj = int'($urandom % 50);
      mi  = (maj == 0) ? 0 : int'($urandom % (maj + 1));
      run_line(maj, mi, 1'($urandom), 1'($urandom), 1'($urandom),
               1024 + int'($urandom % 2048), int'($urandom % 16), 16,
               16'($urandom), 1'($urandom), 1'($urandom), "R2", 0);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #700000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL R9 watchdog expired: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule